// File: doc/BRIEF.md
# Bit-Reversed Pulse Density Modulator

This block turns an unsigned density word into a one-bit stream whose number of high cycles over each window of 2^N clocks equals that word. The high cycles are spread evenly through the window rather than grouped into one burst, which gives a smoother output than plain pulse-width modulation. It has no feedback loop. A free-running N-bit counter steps once per clock. The position of the counter's lowest set bit selects one bit of the density word, held in bit-reversed order, and that bit becomes the next output.

A user writes a new density by presenting it on the data input together with a one-cycle load strobe. The counter keeps running across loads. The output is a registered single bit, suited to an external low-pass filter or to direct gating of downstream logic.

Top module: `pdm_bitrev_gen`

## Requirements
- R1: The internal N-bit counter is cleared by reset, then advances by one on every clock and wraps from 2^N-1 to 0 with no stall.
- R2: For a nonzero counter value c whose lowest set bit is at index i, the output produced from c equals density bit N-1-i. With density bit N-1 set, every odd counter value gives a high output, which is every second clock.
- R3: A counter value of 0 always gives a low output, so at most 2^N-1 high cycles fall in one period (density all ones gives 2^N-1).
- R4: With the density held constant, any 2^N consecutive output cycles contain exactly as many high cycles as the unsigned density value.
- R5: When the density is 1, exactly one high cycle occurs per period, and it comes from counter value 2^(N-1).
- R6: The density is captured only on a clock where load_en is high. The new value governs the output one clock later. While load_en is low, changes on density_in have no effect, and a load never resets the counter.
- R7: A synchronous active-low reset clears the counter and the stored density, and the output reads low while reset is applied and afterwards until a nonzero density is loaded.
- R8: The output is registered: the result for counter value c appears on pulse_out one clock after the counter holds c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_en | input | 1 | Strobe that captures density_in on this clock |
| density_in | input | WIDTH | Unsigned density, number of high cycles per 2^WIDTH clocks |
| pulse_out | output | 1 | Registered pulse-density output |

## Verification
A load presented before clock edge L is stored at L, and the first output that depends on it appears after edge L+1. The bench therefore starts every per-period count on the sample that follows edge L+1 and counts 2^N samples from there. Positions are checked every cycle against a model that advances its own counter at each rising edge. That model finds the lowest set bit with a loop, and its prediction is compared with pulse_out at the falling edge after the edge that registered it. Reset takes effect at the first edge it is low, and the output is sampled half a clock later.

// File: rtl/pdm_pkg.sv
// Package: shared limits for the bit-reversed pulse density modulator.
// Assumes: users keep WIDTH inside [PDM_MIN_WIDTH, PDM_MAX_WIDTH].
package pdm_pkg;
    localparam int PDM_MIN_WIDTH     = 2;
    localparam int PDM_MAX_WIDTH     = 16;
    localparam int PDM_DEFAULT_WIDTH = 8;
endpackage

// File: rtl/pdm_free_counter.sv
// Module: free-running phase counter.
// Advances by one on every clock and wraps naturally at 2^WIDTH.
// Assumes: synchronous active-low reset; no enable by design.
module pdm_free_counter #(
    parameter int WIDTH = pdm_pkg::PDM_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] count_q
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    // Purpose: step the phase every clock, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_q + STEP;
    end
endmodule

// File: rtl/pdm_density_reg.sv
// Module: density store in reversed bit order.
// Bit k of the stored word holds density bit WIDTH-1-k, so index k is
// selected by counter values whose lowest set bit sits at k.
// Assumes: load_en is a single-clock strobe; value held otherwise.
module pdm_density_reg #(
    parameter int WIDTH = pdm_pkg::PDM_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] density_in,
    output logic [WIDTH-1:0] rev_q
);
    logic [WIDTH-1:0] rev_d;

    // Purpose: mirror the incoming word end for end.
    for (genvar k = 0; k < WIDTH; k++) begin : g_mirror
        assign rev_d[k] = density_in[WIDTH-1-k];
    end

    // Purpose: capture on strobe, clear on reset, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)       rev_q <= '0;
        else if (load_en) rev_q <= rev_d;
    end
endmodule

// File: rtl/pdm_lsb_mask.sv
// Module: lowest-set-bit isolator.
// A running OR climbs from bit 0 upward; each position keeps its bit
// only where the running OR of the positions below it is still zero.
// Result is one-hot for a nonzero input and all zero for zero.
// Assumes: purely combinational, depth grows linearly with WIDTH.
module pdm_lsb_mask #(
    parameter int WIDTH = pdm_pkg::PDM_DEFAULT_WIDTH
) (
    input  logic [WIDTH-1:0] value_in,
    output logic [WIDTH-1:0] mask_out
);
    logic [WIDTH-1:0] seen;

    assign seen[0]     = value_in[0];
    assign mask_out[0] = value_in[0];

    // Purpose: build the prefix OR chain and the first-one mask.
    for (genvar k = 1; k < WIDTH; k++) begin : g_chain
        assign seen[k]     = seen[k-1] | value_in[k];
        assign mask_out[k] = seen[k] & ~seen[k-1];
    end
endmodule

// File: rtl/pdm_bitrev_gen.sv
// Top: bit-reversed pulse density modulator.
// High cycles per 2^WIDTH clocks equal the loaded density, spread like a
// binary rate multiplier. Output registered; one clock latency from the
// counter value that selects it. Counter 0 always yields a low output.
// Assumes: synchronous active-low reset; WIDTH from 2 to 16.
module pdm_bitrev_gen #(
    parameter int WIDTH = pdm_pkg::PDM_DEFAULT_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [WIDTH-1:0] density_in,
    output logic             pulse_out
);
    logic [WIDTH-1:0] cnt_q;
    logic [WIDTH-1:0] rev_q;
    logic [WIDTH-1:0] lsb_mask;
    logic             pulse_d;

    pdm_free_counter #(.WIDTH(WIDTH)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_q (cnt_q)
    );

    pdm_density_reg #(.WIDTH(WIDTH)) u_dens (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .density_in (density_in),
        .rev_q      (rev_q)
    );

    pdm_lsb_mask #(.WIDTH(WIDTH)) u_mask (
        .value_in (cnt_q),
        .mask_out (lsb_mask)
    );

    // Purpose: select the reversed density bit under the first-one mask.
    always_comb pulse_d = |(lsb_mask & rev_q);

    // Purpose: register the output, low during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_out <= 1'b0;
        else        pulse_out <= pulse_d;
    end
endmodule

// File: rtl/pdm_bitrev_gen_chk.sv
// Checker: temporal properties of pdm_bitrev_gen, attached by bind.
// Assumes: reset is active low and synchronous.
module pdm_bitrev_gen_chk #(
    parameter int WIDTH = pdm_pkg::PDM_DEFAULT_WIDTH
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_en,
    input logic             pulse_out,
    input logic [WIDTH-1:0] cnt_q,
    input logic [WIDTH-1:0] rev_q,
    input logic [WIDTH-1:0] lsb_mask
);
    localparam logic [WIDTH-1:0] ALL_ONES = '1;

    // R1: counter steps by one where it does not wrap
    p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cnt_q != ALL_ONES) |=> (cnt_q == $past(cnt_q) + WIDTH'(1)));

    // R1: counter wraps to zero
    p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cnt_q == ALL_ONES) |=> (cnt_q == '0));

    // R2: mask marks exactly one position for a nonzero counter
    p_mask_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lsb_mask) == ((cnt_q != '0) ? 1 : 0));

    // R2: odd counter values follow the density MSB
    p_odd_follows_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cnt_q[0]) |=> (pulse_out == $past(rev_q[0])));

    // R3: counter zero yields a low output next clock
    p_zero_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && cnt_q == '0) |=> !pulse_out);

    // R6: stored density holds without a strobe
    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !load_en) |=> (rev_q == $past(rev_q)));
endmodule

bind pdm_bitrev_gen pdm_bitrev_gen_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .pulse_out (pulse_out),
    .cnt_q     (cnt_q),
    .rev_q     (rev_q),
    .lsb_mask  (lsb_mask)
);

// File: tb/pdm_bitrev_gen_tb_top.sv
module pdm_bitrev_gen_tb_top;
    localparam int W      = 8;
    localparam int PERIOD = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_en = 1'b0;
    logic [W-1:0] density_in = '0;
    logic         pulse_out;

    int n_checks = 0;
    int n_fail   = 0;
    int pos_err  = 0;
    bit done     = 0;

    // reference model state
    int           m_cnt = 0;
    logic [W-1:0] m_dens = '0;
    logic         exp_q = 1'b0;
    int           src_q = 0;

    pdm_bitrev_gen #(.WIDTH(W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .density_in (density_in),
        .pulse_out  (pulse_out)
    );

    always #4 clk = ~clk;

    function automatic logic ref_pulse(input int c, input logic [W-1:0] d);
        if (c == 0) return 1'b0;
        for (int i = 0; i < W; i++) begin
            if (c[i]) return d[W-1-i];
        end
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_dens = '0; exp_q = 1'b0; src_q = 0;
        end else begin
            exp_q = ref_pulse(m_cnt, m_dens);
            src_q = m_cnt;
            m_cnt = (m_cnt + 1) % PERIOD;
            if (load_en) m_dens = density_in;
        end
    end

    always @(negedge clk) begin
        if (pulse_out !== exp_q) pos_err++;
    end

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic load(input logic [W-1:0] d);
        @(negedge clk); density_in = d; load_en = 1'b1;
        @(negedge clk); load_en = 1'b0;
    endtask

    // counts high samples over one period, starting one clock after a load
    task automatic count_period(output int hits, output int last_src);
        hits = 0; last_src = -1;
        for (int k = 0; k < PERIOD; k++) begin
            @(negedge clk);
            if (pulse_out) begin hits++; last_src = src_q; end
        end
    endtask

    task automatic t_reset();
        int h, s;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 output low in reset", int'(pulse_out), 0);
        rst_n = 1'b1;
        count_period(h, s);
        check("R7 no pulses after reset", h, 0);
    endtask

    task automatic t_density(input logic [W-1:0] d, input string tag);
        int h, s;
        pos_err = 0;
        load(d);
        count_period(h, s);
        check(tag, h, int'(d));
        check("R2 R8 positions vs model", pos_err, 0);
    endtask

    task automatic t_msb_only();
        int h, s, odd_miss;
        load(8'h80);
        odd_miss = 0; h = 0;
        for (int k = 0; k < PERIOD; k++) begin
            @(negedge clk);
            if (pulse_out) h++;
            if (pulse_out != (src_q % 2 == 1)) odd_miss++;
        end
        check("R2 msb gives odd-count pulses", odd_miss, 0);
        check("R2 msb pulse count", h, PERIOD / 2);
    endtask

    task automatic t_lsb_only();
        int h, s;
        load(8'h01);
        count_period(h, s);
        check("R5 one pulse per period", h, 1);
        check("R5 pulse from counter 2^(N-1)", s, PERIOD / 2);
    endtask

    task automatic t_full();
        int h, s;
        pos_err = 0;
        load('1);
        count_period(h, s);
        check("R3 full scale gives 2^N-1", h, PERIOD - 1);
        check("R3 R1 positions vs model", pos_err, 0);
    endtask

    task automatic t_ignore_no_strobe();
        int h, s;
        load(8'd37);
        @(negedge clk); density_in = 8'd200;
        count_period(h, s);
        check("R6 data ignored without strobe", h, 37);
    endtask

    task automatic t_reset_mid();
        int h, s;
        load(8'd99);
        repeat (17) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R7 mid-run reset output low", int'(pulse_out), 0);
        rst_n = 1'b1;
        count_period(h, s);
        check("R7 density cleared by reset", h, 0);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_density(8'd1,   "R4 count d=1");
        t_density(8'd85,  "R4 count d=85");
        t_density(8'd170, "R4 count d=170");
        t_density(8'd3,   "R6 R4 reload without counter reset");
        t_msb_only();
        t_lsb_only();
        t_full();
        t_ignore_no_strobe();
        t_reset_mid();
        t_density(8'd200, "R4 count d=200");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule